// File: doc/BRIEF.md
# Single-Accumulator Processor with Numbered Device Ports

This block is a small sequencer-class processor built around one working register, the accumulator. Every instruction is one word: an operation code in the upper four bits and a twelve-bit field below it. The core fetches the word the program counter points at into its instruction register, steps the program counter by one, and in the following cycle carries the instruction out. Instructions and data share one word-addressed memory.

The twelve-bit field has two uses. For memory operations it is a word address. For the two device operations it is a device number, which is placed on a separate device port together with a read or write strobe. A device read returns its word in the same cycle as the strobe. The core suits control jobs that shuttle values between peripherals with a little arithmetic in between. It stops at a halt instruction and stays stopped until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core fetches from address `RESET_PC` (default 0x300) with `mem_rd` high, the accumulator starts at 0, and `mem_wr`, `dev_rd`, `dev_wr` and `halted` are low.
- R2: Each instruction takes exactly two cycles: a fetch cycle that reads memory at the program counter, then one execute cycle. The program counter advances by one word per instruction, so fetch addresses run RESET_PC, RESET_PC+1, and so on.
- R3: Operation code 4'b0101 reads the word at the twelve-bit address and adds it to the accumulator, wrapping modulo 2^16.
- R4: Operation code 4'b0011 pulses `dev_rd` for one execute cycle, with `dev_num` equal to the twelve-bit field, and loads the accumulator with `dev_rdata` from that cycle.
- R5: Operation code 4'b0111 pulses `dev_wr` for one execute cycle, with `dev_num` equal to the twelve-bit field and `dev_wdata` equal to the accumulator. The accumulator is left unchanged.
- R6: Operation code 4'b0001 loads the accumulator from the memory word at the twelve-bit address. Operation code 4'b0010 writes the accumulator to that address with `mem_wr`.
- R7: Operation code 4'b0000 halts the core, whatever its field holds. `halted` then stays high and no strobe of any kind is issued until reset.
- R8: Every other operation code is a no-op: its execute cycle has no strobe, and the accumulator keeps its value.
- R9: The program 0x3005, 0x5940, 0x7006 at addresses 0x300 to 0x302, with device 5 returning 3 and word 0x940 holding 2, writes 5 to device 6.
- R10: At most one of `mem_rd`, `mem_wr`, `dev_rd` and `dev_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory word address: the program counter in fetch, the field in execute |
| mem_rd | output | 1 | Memory read strobe; data is expected on mem_rdata in the same cycle |
| mem_rdata | input | 16 | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| dev_num | output | 12 | Device number taken from the instruction field |
| dev_rd | output | 1 | Device read strobe, one cycle |
| dev_rdata | input | 16 | Device read data, returned in the strobe cycle |
| dev_wr | output | 1 | Device write strobe, one cycle |
| dev_wdata | output | 16 | Device write data (the accumulator) |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest case to reach from the ports is an accumulator value that is never written out. It arises after undefined operation codes, after device reads, or after an addition that overflows, and it only becomes visible when a later device write exposes it. The bench generates random programs that mix every operation code, including undefined ones, with data words drawn across the full 16-bit range. It also runs a directed program that adds 0xFFFF and 3. A reference interpreter predicts, for each program, the exact sequence of memory reads, memory writes, device reads and device writes, as well as the cycle on which the core halts.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT = 4'b0000,
        OP_LDM  = 4'b0001,
        OP_STM  = 4'b0010,
        OP_IN   = 4'b0011,
        OP_ADD  = 4'b0101,
        OP_OUT  = 4'b0111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_STOP  = 2'd2
    } cpu_state_e;

    typedef enum logic [1:0] {
        ACC_KEEP = 2'd0,
        ACC_MEM  = 2'd1,
        ACC_SUM  = 2'd2,
        ACC_DEV  = 2'd3
    } acc_sel_e;

    typedef struct packed {
        logic     mem_rd;
        logic     mem_wr;
        logic     dev_rd;
        logic     dev_wr;
        logic     stop;
        acc_sel_e acc_sel;
    } exec_ctl_s;
endpackage

// File: rtl/acc_decode.sv
`timescale 1ns/1ps
module acc_decode
    import acc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output exec_ctl_s        ctl
);
    always_comb begin
        ctl = '{mem_rd: 1'b0, mem_wr: 1'b0, dev_rd: 1'b0, dev_wr: 1'b0,
                stop: 1'b0, acc_sel: ACC_KEEP};
        case (opcode_e'(opcode))
            OP_HALT: ctl.stop = 1'b1;
            OP_LDM: begin
                ctl.mem_rd  = 1'b1;
                ctl.acc_sel = ACC_MEM;
            end
            OP_STM: ctl.mem_wr = 1'b1;
            OP_IN: begin
                ctl.dev_rd  = 1'b1;
                ctl.acc_sel = ACC_DEV;
            end
            OP_ADD: begin
                ctl.mem_rd  = 1'b1;
                ctl.acc_sel = ACC_SUM;
            end
            OP_OUT: ctl.dev_wr = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
    import acc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  acc_sel_e          sel,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] dev_word,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        case (sel)
            ACC_MEM: result = mem_word;
            ACC_SUM: result = acc + mem_word;
            ACC_DEV: result = dev_word;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
`timescale 1ns/1ps
module acc_core
    import acc_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int RESET_PC = 12'h300
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [WORD_W-OPC_W-1:0]   mem_addr,
    output logic                      mem_rd,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic                      mem_wr,
    output logic [WORD_W-1:0]         mem_wdata,
    output logic [WORD_W-OPC_W-1:0]   dev_num,
    output logic                      dev_rd,
    input  logic [WORD_W-1:0]         dev_rdata,
    output logic                      dev_wr,
    output logic [WORD_W-1:0]         dev_wdata,
    output logic                      halted
);
    localparam int AW = WORD_W - OPC_W;

    typedef struct packed {
        cpu_state_e        st;
        logic [AW-1:0]     pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] acc;
    } core_s;

    core_s q, d;

    logic [OPC_W-1:0]  opc_now;
    logic [AW-1:0]     field_now;
    exec_ctl_s         ctl;
    logic [WORD_W-1:0] alu_out;

    // signals exposed to the bound checker
    logic              in_fetch;
    logic [AW-1:0]     pc_now;
    logic [WORD_W-1:0] acc_now;

    assign opc_now   = q.ir[WORD_W-1 -: OPC_W];
    assign field_now = q.ir[AW-1:0];
    assign in_fetch  = (q.st == ST_FETCH);
    assign pc_now    = q.pc;
    assign acc_now   = q.acc;

    acc_decode u_dec (
        .opcode (opc_now),
        .ctl    (ctl)
    );

    acc_alu #(.WORD_W(WORD_W)) u_alu (
        .sel      (ctl.acc_sel),
        .acc      (q.acc),
        .mem_word (mem_rdata),
        .dev_word (dev_rdata),
        .result   (alu_out)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;
        dev_num   = field_now;
        mem_wdata = q.acc;
        dev_wdata = q.acc;
        halted    = 1'b0;
        case (q.st)
            ST_FETCH: begin
                mem_rd = 1'b1;
                d.ir   = mem_rdata;
                d.pc   = q.pc + 1'b1;
                d.st   = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr = field_now;
                mem_rd   = ctl.mem_rd;
                mem_wr   = ctl.mem_wr;
                dev_rd   = ctl.dev_rd;
                dev_wr   = ctl.dev_wr;
                d.acc    = alu_out;
                d.st     = ctl.stop ? ST_STOP : ST_FETCH;
            end
            default: begin
                halted = 1'b1;
                d.st   = ST_STOP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_FETCH;
            q.pc  <= AW'(RESET_PC);
            q.ir  <= '0;
            q.acc <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/acc_core_chk.sv
`timescale 1ns/1ps
module acc_core_chk #(
    parameter int WORD_W   = 16,
    parameter int AW       = 12,
    parameter int RESET_PC = 12'h300
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              dev_rd,
    input logic              dev_wr,
    input logic [WORD_W-1:0] dev_rdata,
    input logic              halted,
    input logic              in_fetch,
    input logic [AW-1:0]     pc_now,
    input logic [WORD_W-1:0] acc_now
);
    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_rd && mem_addr == AW'(RESET_PC) && acc_now == '0)); // R1

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch |-> (mem_rd && mem_addr == pc_now)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch |=> (!in_fetch && pc_now == $past(pc_now) + 1'b1)); // R2

    AST_DEV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |=> (acc_now == $past(dev_rdata))); // R4

    AST_OUT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |=> (acc_now == $past(acc_now))); // R5

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R7

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_rd || mem_wr || dev_rd || dev_wr)); // R7

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr, dev_rd, dev_wr}) <= 1); // R10
endmodule

bind acc_core acc_core_chk #(
    .WORD_W   (WORD_W),
    .AW       (WORD_W - acc_pkg::OPC_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .dev_rd    (dev_rd),
    .dev_wr    (dev_wr),
    .dev_rdata (dev_rdata),
    .halted    (halted),
    .in_fetch  (in_fetch),
    .pc_now    (pc_now),
    .acc_now   (acc_now)
);

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;
    localparam int W  = 16;
    localparam int AW = 12;
    localparam int PC0 = 12'h300;
    localparam int LOGN = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] mem_addr, dev_num;
    logic mem_rd, mem_wr, dev_rd, dev_wr, halted;
    logic [W-1:0] mem_rdata, mem_wdata, dev_rdata, dev_wdata;

    always #2.5 clk = ~clk;

    acc_core #(.WORD_W(W), .RESET_PC(PC0)) uut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .dev_num(dev_num), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata), .halted(halted)
    );

    logic [W-1:0] mem [0:4095];
    logic [W-1:0] ref_mem [0:4095];

    function automatic logic [W-1:0] dev_val(input logic [AW-1:0] n);
        if (n == 12'd5) return 16'd3;
        return 16'((32'(n) * 32'd40503 + 32'd7) ^ 32'hA5C3);
    endfunction

    assign mem_rdata = mem[mem_addr];
    assign dev_rdata = dev_val(dev_num);

    always @(posedge clk) if (rst_n && mem_wr) mem[mem_addr] <= mem_wdata;

    // observed traffic
    int act_rd [LOGN]; int n_act_rd;
    int act_mwa[LOGN]; int act_mwd[LOGN]; int n_act_mw;
    int act_dwn[LOGN]; int act_dwd[LOGN]; int n_act_dw;
    int act_drn[LOGN]; int n_act_dr;
    // predicted traffic
    int exp_rd [LOGN]; int n_exp_rd;
    int exp_mwa[LOGN]; int exp_mwd[LOGN]; int n_exp_mw;
    int exp_dwn[LOGN]; int exp_dwd[LOGN]; int n_exp_dw;
    int exp_drn[LOGN]; int n_exp_dr;
    int exp_instrs;

    int n_checks = 0;
    int n_fail = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_rd && n_act_rd < LOGN) begin act_rd[n_act_rd] = int'(mem_addr); n_act_rd++; end
            if (mem_wr && n_act_mw < LOGN) begin
                act_mwa[n_act_mw] = int'(mem_addr); act_mwd[n_act_mw] = int'(mem_wdata); n_act_mw++;
            end
            if (dev_wr && n_act_dw < LOGN) begin
                act_dwn[n_act_dw] = int'(dev_num); act_dwd[n_act_dw] = int'(dev_wdata); n_act_dw++;
            end
            if (dev_rd && n_act_dr < LOGN) begin act_drn[n_act_dr] = int'(dev_num); n_act_dr++; end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference interpreter over ref_mem
    task automatic predict();
        int pc = PC0;
        int acc = 0;
        n_exp_rd = 0; n_exp_mw = 0; n_exp_dw = 0; n_exp_dr = 0; exp_instrs = 0;
        for (int step = 0; step < 300; step++) begin
            logic [W-1:0] ins = ref_mem[pc];
            int f = int'(ins[11:0]);
            exp_rd[n_exp_rd++] = pc;
            pc = (pc + 1) % 4096;
            exp_instrs++;
            case (ins[15:12])
                4'b0000: return;
                4'b0001: begin exp_rd[n_exp_rd++] = f; acc = int'(ref_mem[f]); end
                4'b0010: begin exp_mwa[n_exp_mw] = f; exp_mwd[n_exp_mw++] = acc; ref_mem[f] = W'(acc); end
                4'b0011: begin exp_drn[n_exp_dr++] = f; acc = int'(dev_val(AW'(f))); end
                4'b0101: begin exp_rd[n_exp_rd++] = f; acc = (acc + int'(ref_mem[f])) & 32'hFFFF; end
                4'b0111: begin exp_dwn[n_exp_dw] = f; exp_dwd[n_exp_dw++] = acc; end
                default: ;
            endcase
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 12'h900; i < 12'hA00; i++) mem[i] = W'($urandom);
    endtask

    task automatic run_prog(input string tag);
        int cyc = 0;
        bit done = 0;
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
        predict();
        @(negedge clk);
        rst_n = 1'b0;
        n_act_rd = 0; n_act_mw = 0; n_act_dw = 0; n_act_dr = 0;
        @(negedge clk);
        // R1: state while reset is held
        check("R1", {tag, " reset fetch address"}, int'(mem_addr), PC0);
        check("R1", {tag, " reset mem_rd"}, int'(mem_rd), 1);
        check("R1", {tag, " reset other strobes/halted"},
              int'({mem_wr, dev_rd, dev_wr, halted}), 0);
        rst_n = 1'b1;
        while (!done && cyc < 2000) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (halted) done = 1;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R7 %s watchdog: actual no halt expected halt", tag);
        end
        // R2: two cycles per instruction up to and including halt
        check("R2", {tag, " cycles to halt"}, cyc, 2 * exp_instrs);
        repeat (6) @(negedge clk);
        check("R7", {tag, " halted stays high"}, int'(halted), 1);
        check("R2", {tag, " memory read count"}, n_act_rd, n_exp_rd);
        for (int i = 0; i < n_exp_rd && i < n_act_rd; i++)
            check("R2", {tag, " read address"}, act_rd[i], exp_rd[i]);
        check("R6", {tag, " memory write count"}, n_act_mw, n_exp_mw);
        for (int i = 0; i < n_exp_mw && i < n_act_mw; i++) begin
            check("R6", {tag, " write address"}, act_mwa[i], exp_mwa[i]);
            check("R6", {tag, " write data"}, act_mwd[i], exp_mwd[i]);
        end
        check("R4", {tag, " device read count"}, n_act_dr, n_exp_dr);
        for (int i = 0; i < n_exp_dr && i < n_act_dr; i++)
            check("R4", {tag, " device read number"}, act_drn[i], exp_drn[i]);
        check("R5", {tag, " device write count"}, n_act_dw, n_exp_dw);
        for (int i = 0; i < n_exp_dw && i < n_act_dw; i++) begin
            check("R5", {tag, " device write number"}, act_dwn[i], exp_dwn[i]);
            check("R3", {tag, " device write data"}, act_dwd[i], exp_dwd[i]);
        end
    endtask

    function automatic logic [W-1:0] rand_instr();
        int k = int'($urandom % 6);
        logic [AW-1:0] da = AW'(12'h900 + ($urandom % 256));
        logic [AW-1:0] dn = AW'($urandom);
        case (k)
            0: return {4'b0001, da};
            1: return {4'b0010, da};
            2: return {4'b0101, da};
            3: return {4'b0011, dn};
            4: return {4'b0111, dn};
            default: begin
                logic [3:0] u;
                case ($urandom % 4)
                    0: u = 4'b0100;
                    1: u = 4'b0110;
                    default: u = 4'(8 + ($urandom % 8));
                endcase
                return {u, dn};
            end
        endcase
    endfunction

    initial begin
        int unsigned seed_init = $urandom(32'd20240611);
        n_act_rd = 0; n_act_mw = 0; n_act_dw = 0; n_act_dr = 0;
        if (seed_init == 0) ;

        // R9: worked example program
        clear_mem();
        mem[12'h300] = 16'h3005; mem[12'h301] = 16'h5940; mem[12'h302] = 16'h7006;
        mem[12'h303] = 16'h0000; mem[12'h940] = 16'h0002;
        run_prog("example");
        check("R9", "example writes device 6", act_dwn[0], 6);
        check("R9", "example writes value 5", act_dwd[0], 5);

        // R3: wrap of the addition
        clear_mem();
        mem[12'h9F0] = 16'hFFFF; mem[12'h9F1] = 16'h0003;
        mem[12'h300] = 16'h19F0; mem[12'h301] = 16'h59F1; mem[12'h302] = 16'h7001;
        mem[12'h303] = 16'h0ABC;
        run_prog("wrap");
        check("R3", "0xFFFF+3 wraps to 2", act_dwd[0], 2);

        // R8 and R1: undefined opcodes leave the reset accumulator of 0
        clear_mem();
        mem[12'h300] = 16'h4123; mem[12'h301] = 16'hF9FF; mem[12'h302] = 16'h6905;
        mem[12'h303] = 16'h8000; mem[12'h304] = 16'h7002; mem[12'h305] = 16'h0000;
        run_prog("undef");
        check("R8", "no-ops keep accumulator at 0", act_dwd[0], 0);
        check("R8", "no-ops make no memory writes", n_act_mw, 0);

        // random programs
        for (int p = 0; p < 8; p++) begin
            int len = 20 + int'($urandom % 40);
            clear_mem();
            for (int i = 0; i < len; i++) mem[PC0 + i] = rand_instr();
            mem[PC0 + len] = {4'b0000, 12'($urandom)};
            run_prog($sformatf("random%0d", p));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule